// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Sequencer

After a host has issued a nonvolatile write to a slave on a two-wire serial bus and stopped the bus, the slave ignores its own address until the internal write has finished. This sequencer works out when the slave is ready again. It repeatedly addresses the slave until the slave acknowledges. It does this through a byte-level bus engine that accepts three commands: a start condition, a byte transfer and a stop condition. For every byte it transfers, the engine reports the acknowledge bit it sampled.

Each attempt is a start followed by the slave address byte with the write direction bit. When the address is not acknowledged, the sequencer stops the bus and tries again. When the address is acknowledged, it does one of two things:
- If an instruction was queued when polling began, it sends that instruction byte at once, with no new start.
- Otherwise it stops the bus and finishes.

A programmable attempt limit ends a slave that never answers with a stop and a timeout flag. The number of attempts made stays visible on a counter until the next run.

Top module: `ack_poll_sequencer`

## Requirements
- R1: After reset the block is idle. It has no command valid, busy, done and timeout are low, and the poll count is zero.
- R2: Each attempt issues a start command (op code 0), then a byte command (op code 1) carrying the 7-bit slave address in bits 7:1 and a 0 write bit in bit 0. The poll count goes up by one per attempt and is cleared when a run begins.
- R3: When the address result reports no acknowledge (ack input 0) and the limit is not reached, the next command is a stop (op code 2), followed by a new attempt.
- R4: When the address is acknowledged and an instruction was queued, the next command is a byte carrying the instruction, with no start or stop before it. Done follows that byte's result.
- R5: When the address is acknowledged and no instruction was queued, the next command is a stop, after which done is signalled.
- R6: A run never makes more than max(limit, 1) attempts. A missing acknowledge on the last allowed attempt leads to a stop, the timeout flag and done, and no instruction byte is sent.
- R7: A command stays valid, with unchanged op code and data, until the engine accepts it.
- R8: The address, the queued-instruction flag, the instruction byte and the limit are sampled when a run begins. A start request while busy is ignored.
- R9: Done is a one-cycle pulse. The timeout flag and the poll count hold their values until the next run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a polling run (accepted only when idle) |
| slave_addr_i | input | 7 | Slave address |
| has_instr_i | input | 1 | An instruction byte is queued to follow the acknowledge |
| instr_i | input | 8 | Queued instruction byte |
| max_polls_i | input | 8 | Attempt limit (0 behaves as 1) |
| cmd_valid_o | output | 1 | Command offered to the byte engine |
| cmd_ready_i | input | 1 | Byte engine accepts the command |
| cmd_op_o | output | 2 | 0 start, 1 byte, 2 stop |
| cmd_data_o | output | 8 | Byte to send for a byte command |
| res_valid_i | input | 1 | Result strobe for a transferred byte |
| res_ack_i | input | 1 | Sampled acknowledge, 1 = acknowledged |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| timeout_o | output | 1 | Last run ended at the attempt limit |
| poll_count_o | output | 8 | Attempts made in the current or last run |

## Verification
The assertions assume that the byte engine raises its result strobe only while the sequencer is waiting on a byte it has just handed over. This means no earlier than the cycle after that byte was accepted, and never for start or stop commands. The engine model in the bench keeps to this rule: it arms a single pending result only when a byte command is accepted, and releases it one to three cycles later. It varies its ready pattern so that commands are held across idle cycles. It answers address bytes with a chosen number of missing acknowledges before the first acknowledge, which drives runs onto, just under and past the limit.

// File: rtl/ack_poll_pkg.sv
package ack_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_WADDR, ST_STOPR, ST_INSTR, ST_WINSTR, ST_STOPF
  } ap_state_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } ap_op_e;
endpackage

// File: rtl/ap_poll_counter.sv
module ap_poll_counter #(
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [POLL_W-1:0] lim_i,
  output logic [POLL_W-1:0] count_o,
  output logic              at_limit_o
);
  logic [POLL_W-1:0] lim_eff;
  logic [POLL_W-1:0] count_d, count_q;

  assign lim_eff = (lim_i == '0) ? POLL_W'(1) : lim_i;

  always_comb begin
    count_d = count_q;
    if (clr_i)      count_d = '0;
    else if (inc_i) count_d = count_q + POLL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (clr_i || inc_i)   count_q <= count_d;
  end

  assign count_o    = count_q;
  assign at_limit_o = (count_q >= lim_eff);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= lim_eff);
endmodule

// File: rtl/ap_cmd_encode.sv
module ap_cmd_encode
  import ack_poll_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  ap_state_e         state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] instr_i,
  output logic              valid_o,
  output logic [1:0]        op_o,
  output logic [BYTE_W-1:0] data_o
);
  always_comb begin
    valid_o = 1'b1;
    op_o    = OP_BYTE;
    data_o  = '0;
    unique case (state_i)
      ST_START: op_o = OP_START;
      ST_ADDR:  data_o = {addr_i, 1'b0};
      ST_INSTR: data_o = instr_i;
      ST_STOPR, ST_STOPF: op_o = OP_STOP;
      default:  valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ack_poll_sequencer.sv
module ack_poll_sequencer
  import ack_poll_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int POLL_W = 8,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              has_instr_i,
  input  logic [BYTE_W-1:0] instr_i,
  input  logic [POLL_W-1:0] max_polls_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  input  logic              res_valid_i,
  input  logic              res_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [POLL_W-1:0] poll_count_o
);
  ap_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] instr_q;
  logic              next_q;
  logic [POLL_W-1:0] lim_q;
  logic              timeout_q, timeout_d;
  logic              done_q, done_d;
  logic              hs, accept, at_limit, nack_end;

  assign hs       = cmd_valid_o && cmd_ready_i;
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign nack_end = (state_q == ST_WADDR) && res_valid_i && !res_ack_i && at_limit;

  ap_cmd_encode #(.ADDR_W(ADDR_W)) enc_i (
    .state_i (state_q),
    .addr_i  (addr_q),
    .instr_i (instr_q),
    .valid_o (cmd_valid_o),
    .op_o    (cmd_op_o),
    .data_o  (cmd_data_o)
  );

  ap_poll_counter #(.POLL_W(POLL_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .inc_i      ((state_q == ST_START) && hs),
    .lim_i      (lim_q),
    .count_o    (poll_count_o),
    .at_limit_o (at_limit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_START;
      ST_START:  if (hs) state_d = ST_ADDR;
      ST_ADDR:   if (hs) state_d = ST_WADDR;
      ST_WADDR:
        if (res_valid_i) begin
          if (res_ack_i)     state_d = next_q ? ST_INSTR : ST_STOPF;
          else if (at_limit) state_d = ST_STOPF;
          else               state_d = ST_STOPR;
        end
      ST_STOPR:  if (hs) state_d = ST_START;
      ST_INSTR:  if (hs) state_d = ST_WINSTR;
      ST_WINSTR: if (res_valid_i) state_d = ST_IDLE;
      ST_STOPF:  if (hs) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    timeout_d = timeout_q;
    if (accept)        timeout_d = 1'b0;
    else if (nack_end) timeout_d = 1'b1;
    done_d = ((state_q == ST_WINSTR) && res_valid_i) || ((state_q == ST_STOPF) && hs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      timeout_q <= timeout_d;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      instr_q <= '0;
      next_q  <= 1'b0;
      lim_q   <= '0;
    end else if (accept) begin
      addr_q  <= slave_addr_i;
      instr_q <= instr_i;
      next_q  <= has_instr_i;
      lim_q   <= max_polls_i;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = timeout_q;

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)));

  assert_nack_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WADDR && res_valid_i && !res_ack_i) |=> (cmd_valid_o && cmd_op_o == OP_STOP));

  assert_ack_instr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WADDR && res_valid_i && res_ack_i && next_q) |=>
      (cmd_valid_o && cmd_op_o == OP_BYTE && cmd_data_o == instr_q));

  assert_timeout_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (at_limit && poll_count_o != '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (poll_count_o >= $past(poll_count_o)));

  assert_result_expected: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |-> (state_q == ST_WADDR || state_q == ST_WINSTR));
endmodule

// File: tb/ack_poll_sequencer_tb_top.sv
module ack_poll_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] slave_addr_i = '0;
  logic       has_instr_i = 1'b0;
  logic [7:0] instr_i = '0;
  logic [7:0] max_polls_i = '0;
  logic       cmd_valid_o, cmd_ready_i;
  logic [1:0] cmd_op_o;
  logic [7:0] cmd_data_o;
  logic       res_valid_i, res_ack_i;
  logic       busy_o, done_o, timeout_o;
  logic [7:0] poll_count_o;

  always #4 clk = ~clk;

  ack_poll_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .slave_addr_i(slave_addr_i),
    .has_instr_i(has_instr_i), .instr_i(instr_i), .max_polls_i(max_polls_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o),
    .cmd_data_o(cmd_data_o), .res_valid_i(res_valid_i), .res_ack_i(res_ack_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .poll_count_o(poll_count_o)
  );

  int errors = 0;
  int checks = 0;
  logic [9:0] exp_q[$];
  int  nack_left = 0;
  int  pend = 0;
  logic pend_ack = 1'b0;
  logic last_start = 1'b0;
  logic done_seen = 1'b0;
  int  rdy_cnt = 0;
  int  cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    cmd_ready_i = 1'b0;
    res_valid_i = 1'b0;
    res_ack_i   = 1'b0;
  end

  // Byte engine model and scoreboard monitor, all at the falling edge.
  always @(negedge clk) begin
    cyc++;
    res_valid_i = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        res_valid_i = 1'b1;
        res_ack_i   = pend_ack;
      end
    end
    rdy_cnt++;
    cmd_ready_i = rst_n && ((rdy_cnt % 5) != 2) && ((rdy_cnt % 7) != 4);
    if (done_o) done_seen = 1'b1;
    if (cmd_valid_o && cmd_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected command", int'({cmd_op_o, cmd_data_o}), -1);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (e[9:8] == 2'd1 && e[7:0] != {slave_addr_i, 1'b0})
          chk({cmd_op_o, cmd_data_o} == e, "R4 instruction byte", int'({cmd_op_o, cmd_data_o}), int'(e));
        else
          chk({cmd_op_o, cmd_data_o} == e, "R2/R3/R5 command order", int'({cmd_op_o, cmd_data_o}), int'(e));
      end
      if (cmd_op_o == 2'd1) begin
        pend = 1 + (rdy_cnt % 3);
        if (last_start) begin
          if (nack_left > 0) begin nack_left--; pend_ack = 1'b0; end
          else pend_ack = 1'b1;
        end else pend_ack = 1'b1;
      end
      last_start = (cmd_op_o == 2'd0);
    end
  end

  task automatic run(input int k, input bit nxt, input int lim, input logic [6:0] addr,
                     input logic [7:0] ins, input bit glitch);
    int le, att;
    bit to;
    le  = (lim == 0) ? 1 : lim;
    att = (k + 1 < le) ? k + 1 : le;
    to  = (k + 1 > le);
    for (int i = 1; i <= att; i++) begin
      exp_q.push_back({2'd0, 8'h00});
      exp_q.push_back({2'd1, addr, 1'b0});
      if (i < att || to) exp_q.push_back({2'd2, 8'h00});
      else if (nxt)      exp_q.push_back({2'd1, ins});
      else               exp_q.push_back({2'd2, 8'h00});
    end
    @(negedge clk);
    nack_left = k; done_seen = 1'b0;
    slave_addr_i = addr; has_instr_i = nxt; instr_i = ins; max_polls_i = 8'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    slave_addr_i = ~addr; has_instr_i = ~nxt; max_polls_i = 8'd1;
    if (glitch) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    slave_addr_i = addr;
    for (int w = 0; w < 3000 && !done_seen; w++) @(negedge clk);
    chk(done_seen, "R9 done watchdog", int'(done_seen), 1);
    @(negedge clk);
    chk(!done_o, "R9 done single cycle", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk(poll_count_o == 8'(att), "R2/R6 poll count", int'(poll_count_o), att);
    chk(timeout_o == to, "R6 timeout", int'(timeout_o), int'(to));
    chk(exp_q.size() == 0, glitch ? "R8 ignored start" : "R6 no extra commands", exp_q.size(), 0);
    chk(!busy_o && !cmd_valid_o, "R9 idle after done", int'(busy_o), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid_o && !busy_o && !done_o && !timeout_o && poll_count_o == 0,
        "R1 reset state", int'(poll_count_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 1'b0, 5, 7'h50, 8'h00, 1'b0);   // R5 immediate ack
    run(3, 1'b0, 10, 7'h2A, 8'h00, 1'b0);  // R3 retries
    run(2, 1'b1, 8, 7'h51, 8'hA5, 1'b0);   // R4 instruction follows
    run(5, 1'b0, 3, 7'h11, 8'h00, 1'b0);   // R6 timeout
    run(4, 1'b1, 5, 7'h7F, 8'h3C, 1'b0);   // R6 ack on last allowed attempt
    run(2, 1'b0, 0, 7'h01, 8'h00, 1'b0);   // R6 limit zero acts as one
    run(6, 1'b1, 6, 7'h40, 8'hC3, 1'b0);   // R6 timeout suppresses instruction
    run(3, 1'b1, 9, 7'h33, 8'h96, 1'b1);   // R8 start while busy ignored
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule